// File: doc/BRIEF.md
# Sleep Wake and Vectoring Controller

This block sequences the sleep state of a small processor core. When instruction decode issues a sleep request, the controller stops the core with a halt (clock-gate) output and records which interrupt sources were enabled at that moment. Only those recorded sources can end the sleep. Their pending flags are set asynchronously by peripherals that keep running without the system clock. The combined wake request crosses into the clock domain through a two-flop synchronizer. When it arrives, the controller releases the halt and emits a one-cycle wake pulse.

After waking, the core always executes exactly one instruction, the one that follows the sleep instruction. The fetch pipeline reports this through a "next instruction executed" handshake. Once that instruction has retired, the controller does one of two things:
- If the global interrupt enable is set, it issues a single-cycle branch-to-vector request. The same edge clears the global enable, so the service routine cannot be entered again while it is running.
- If the global enable is clear, the core simply carries on and no branch is requested.

A sleep request made while an enabled source is already pending never halts the core; it is treated as an immediate wake. The controller never clears pending flags; software does that. The global enable register is kept inside the block, and software sets or clears it through two strobes.

Top module: `wake_vector_ctrl`

## Requirements
- R1: After a synchronous reset, core_halt, wake_pulse and vec_req are 0 and gie is 0.
- R2: A sleep_req sampled while running, with no source pending whose bit in irq_en is 1, sets core_halt to 1 from the next cycle.
- R3: The wake mask is the value of irq_en at the edge that accepts the sleep. Source i (bit i of irq_pend and irq_en) can end the sleep only if bit i of that mask is 1. Changes to irq_en while halted have no effect.
- R4: If a masked-in pending bit is 1 at edge A while halted, then after edge A+2 core_halt is 0 and wake_pulse is 1 for exactly one cycle. A wake request left over from a previous episode does not end a new sleep.
- R5: A sleep_req sampled while a source is pending with its irq_en bit at 1 leaves core_halt at 0, and wake_pulse is 1 for one cycle after that edge.
- R6: After a wake, vec_req stays 0 until instr_done is sampled 1. If gie is 1 at that edge, vec_req is 1 for exactly the next cycle.
- R7: If gie is 0 when instr_done is sampled after a wake, vec_req stays 0 and the core keeps running.
- R8: The edge that raises vec_req also clears gie. This clear wins over a gie_set in the same cycle.
- R9: gie_set makes gie 1 from the next cycle and gie_clr makes it 0. When both are 1, gie_clr wins.
- R10: sleep_req while core_halt is 1 has no effect: the core stays halted and no wake pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Sleep instruction decoded (one cycle) |
| instr_done | input | 1 | The instruction following the sleep has executed |
| irq_pend | input | NSRC | Per-source pending flags, set asynchronously, cleared by software |
| irq_en | input | NSRC | Per-source enables |
| gie_set | input | 1 | Software strobe setting the global enable |
| gie_clr | input | 1 | Software strobe clearing the global enable |
| core_halt | output | 1 | Halt / clock gate for the core |
| wake_pulse | output | 1 | One-cycle pulse when sleep ends |
| vec_req | output | 1 | One-cycle branch-to-vector request |
| gie | output | 1 | Global interrupt enable state |

## Verification
The bench sweeps every wake mask, every waking source and both global-enable settings. It changes irq_en right after sleep entry, so a design that read live enables instead of the captured mask would wake on the wrong sources or miss the right ones. It times the wake to the third edge after the pending flag rises. It also puts a new sleep directly behind a wake whose flag has just been cleared; a design that left stale synchronizer state in place would wake at once. It checks that no vector request appears before the post-sleep instruction retires, and that a software set of the global enable landing on the vectoring edge does not survive, since that would let the service routine be entered again.

// File: rtl/wvc_pkg.sv
package wvc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_POST  = 2'd2
  } wvc_state_t;
endpackage

// File: rtl/wvc_wake_detect.sv
// Captures the enable mask at sleep entry and forms the raw (asynchronous) wake request.
module wvc_wake_detect #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic            drop,
  input  logic [NSRC-1:0] irq_en,
  input  logic [NSRC-1:0] irq_pend,
  output logic            wake_raw
);
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (capture) mask_q <= irq_en;
    else if (drop)    mask_q <= '0;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = irq_pend[i] & mask_q[i];
  end

  assign wake_raw = |hit;
endmodule

// File: rtl/wvc_sync.sv
// Multi-flop synchronizer with a synchronous flush.
module wvc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst || flush) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/wvc_gie.sv
// Global interrupt enable register; any clear wins over a set.
module wvc_gie (
  input  logic clk,
  input  logic rst,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic vec_clr,
  output logic gie_q
);
  always_ff @(posedge clk) begin
    if (rst)                   gie_q <= 1'b0;
    else if (sw_clr || vec_clr) gie_q <= 1'b0;
    else if (sw_set)           gie_q <= 1'b1;
  end
endmodule

// File: rtl/wake_vector_ctrl.sv
module wake_vector_ctrl
  import wvc_pkg::*;
#(
  parameter int NSRC        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sleep_req,
  input  logic            instr_done,
  input  logic [NSRC-1:0] irq_pend,
  input  logic [NSRC-1:0] irq_en,
  input  logic            gie_set,
  input  logic            gie_clr,
  output logic            core_halt,
  output logic            wake_pulse,
  output logic            vec_req,
  output logic            gie
);
  wvc_state_t state_q;
  logic halt_q, wake_q, vec_q;
  logic now_wake, accept, take_vec, wake_raw, wake_sync;

  // Immediate-wake test uses live enables while the clock is running.
  assign now_wake = |(irq_pend & irq_en);
  assign accept   = (state_q == ST_RUN) && sleep_req;
  assign take_vec = (state_q == ST_POST) && instr_done && gie;

  wvc_wake_detect #(.NSRC(NSRC)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .capture  (accept && !now_wake),
    .drop     (state_q == ST_POST),
    .irq_en   (irq_en),
    .irq_pend (irq_pend),
    .wake_raw (wake_raw)
  );

  wvc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .flush (accept),
    .din   (wake_raw),
    .dout  (wake_sync)
  );

  wvc_gie u_gie (
    .clk     (clk),
    .rst     (rst),
    .sw_set  (gie_set),
    .sw_clr  (gie_clr),
    .vec_clr (take_vec),
    .gie_q   (gie)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      halt_q  <= 1'b0;
      wake_q  <= 1'b0;
      vec_q   <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      vec_q  <= take_vec;
      unique case (state_q)
        ST_RUN: begin
          if (sleep_req) begin
            if (now_wake) begin
              state_q <= ST_POST;
              wake_q  <= 1'b1;
            end else begin
              state_q <= ST_SLEEP;
              halt_q  <= 1'b1;
            end
          end
        end
        ST_SLEEP: begin
          if (wake_sync) begin
            state_q <= ST_POST;
            halt_q  <= 1'b0;
            wake_q  <= 1'b1;
          end
        end
        ST_POST: begin
          if (instr_done) state_q <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign core_halt  = halt_q;
  assign wake_pulse = wake_q;
  assign vec_req    = vec_q;
endmodule

// File: rtl/wvc_checker.sv
module wvc_checker (
  input logic clk,
  input logic rst,
  input logic sleep_req,
  input logic core_halt,
  input logic wake_pulse,
  input logic vec_req,
  input logic gie
);
  p_vec_single_r6: assert property (@(posedge clk) disable iff (rst)
    vec_req |=> !vec_req);
  p_vec_clears_gie_r8: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> !gie);
  p_wake_single_r4: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);
  p_no_vec_halted_r6: assert property (@(posedge clk) disable iff (rst)
    core_halt |-> !vec_req);
  p_halt_from_req_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(core_halt) |-> $past(sleep_req));
  p_release_wakes_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(core_halt) |-> wake_pulse);
endmodule

bind wake_vector_ctrl wvc_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .sleep_req  (sleep_req),
  .core_halt  (core_halt),
  .wake_pulse (wake_pulse),
  .vec_req    (vec_req),
  .gie        (gie)
);

// File: tb/sim_wake_vector_ctrl.sv
`timescale 1ns/1ps
module sim_wake_vector_ctrl;
  localparam int NSRC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0, instr_done = 1'b0, gie_set = 1'b0, gie_clr = 1'b0;
  logic [NSRC-1:0] irq_pend = '0, irq_en = '0;
  logic core_halt, wake_pulse, vec_req, gie;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  wake_vector_ctrl #(.NSRC(NSRC)) u0 (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .instr_done(instr_done),
    .irq_pend(irq_pend), .irq_en(irq_en), .gie_set(gie_set), .gie_clr(gie_clr),
    .core_halt(core_halt), .wake_pulse(wake_pulse), .vec_req(vec_req), .gie(gie)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_pend = '0; irq_en = '0;
    sleep_req = 0; instr_done = 0; gie_set = 0; gie_clr = 0;
    step(); step();
    rst = 1'b0;
  endtask

  // One sleep episode: capture mask, scramble enables, raise one source.
  task automatic episode(input logic [NSRC-1:0] mask, input int src, input bit g);
    bit exp;
    do_reset();
    chk(core_halt == 0 && wake_pulse == 0 && vec_req == 0 && gie == 0, "R1 reset",
        {core_halt, wake_pulse, vec_req, gie}, 0);
    irq_en = mask;
    if (g) begin
      gie_set = 1; step(); gie_set = 0;
      chk(gie == 1, "R9 gie set", gie, 1);
    end
    sleep_req = 1; step(); sleep_req = 0;
    irq_en = ~mask;
    chk(core_halt == 1, "R2 halt on sleep", core_halt, 1);
    sleep_req = 1; step(); sleep_req = 0;
    chk(core_halt == 1 && wake_pulse == 0, "R10 sleep while halted", {core_halt, wake_pulse}, 2);
    irq_pend = NSRC'(1) << src;
    step();
    chk(core_halt == 1, "R4 still halted A", core_halt, 1);
    step();
    chk(core_halt == 1, "R4 still halted A+1", core_halt, 1);
    step();
    exp = mask[src];
    chk(core_halt == !exp, "R3 wake by captured mask", core_halt, !exp);
    chk(wake_pulse == exp, "R4 wake pulse", wake_pulse, exp);
    step();
    chk(wake_pulse == 0, "R4 wake single cycle", wake_pulse, 0);
    if (exp) begin
      step();
      chk(vec_req == 0, "R6 no vector before instr_done", vec_req, 0);
      instr_done = 1; step(); instr_done = 0;
      chk(vec_req == g, g ? "R6 vector after instr" : "R7 no vector gie clear", vec_req, g);
      chk(gie == 0, "R8 gie cleared", gie, 0);
      step();
      chk(vec_req == 0, "R6 vector single cycle", vec_req, 0);
    end
    irq_pend = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int m = 0; m < (1 << NSRC); m++)
      for (int s = 0; s < NSRC; s++)
        for (int g = 0; g < 2; g++)
          episode(NSRC'(m), s, g[0]);

    // R5: immediate wake per source
    for (int s = 0; s < NSRC; s++) begin
      do_reset();
      irq_en = NSRC'(1) << s; irq_pend = NSRC'(1) << s;
      sleep_req = 1; step(); sleep_req = 0;
      chk(core_halt == 0 && wake_pulse == 1, "R5 immediate wake", {core_halt, wake_pulse}, 1);
      step();
      chk(core_halt == 0 && wake_pulse == 0, "R5 no halt after", {core_halt, wake_pulse}, 0);
    end

    // R8: gie_set coinciding with the vector edge loses
    do_reset();
    gie_set = 1; step(); gie_set = 0;
    irq_en = 1; irq_pend = 1;
    sleep_req = 1; step(); sleep_req = 0;
    instr_done = 1; gie_set = 1; step(); instr_done = 0; gie_set = 0;
    chk(vec_req == 1, "R8 vector issued", vec_req, 1);
    chk(gie == 0, "R8 clear wins over set", gie, 0);

    // R9: clear wins over set
    do_reset();
    gie_set = 1; gie_clr = 1; step(); gie_set = 0; gie_clr = 0;
    chk(gie == 0, "R9 clr wins", gie, 0);
    gie_set = 1; step(); gie_set = 0;
    chk(gie == 1, "R9 set", gie, 1);
    gie_clr = 1; step(); gie_clr = 0;
    chk(gie == 0, "R9 clr", gie, 0);

    // R4: stale wake from previous episode must not end a new sleep
    do_reset();
    irq_en = 1;
    sleep_req = 1; step(); sleep_req = 0;
    irq_pend = 1; step(); step(); step();
    chk(wake_pulse == 1, "R4 first wake", wake_pulse, 1);
    instr_done = 1; step(); instr_done = 0;
    irq_pend = 0; sleep_req = 1; step(); sleep_req = 0;
    for (int k = 0; k < 4; k++) begin
      chk(core_halt == 1 && wake_pulse == 0, "R4 stale request ignored", {core_halt, wake_pulse}, 2);
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule